// File: doc/BRIEF.md
# Quarter-Cycle I/Q Sampling Detector

This block turns a stream of signed ADC samples of an intermediate-frequency signal into in-phase and quadrature values. It works when the sample clock is locked so that each sample lands exactly a quarter of an IF period, plus whole periods, after the previous one. A 50 MHz IF sampled at 40 MSPS is one such case: each sample advances the IF phase by 450 degrees, which is 90 degrees modulo 360. The samples then repeat the pattern +I, +Q, -I, -Q. The detector follows the position in that four-step pattern and inverts the sign of the second half. Each I value is paired with the Q value that follows it, so one path gives both amplitude and phase information. No mixer, oscillator or filter is needed.

A block of 2^AVG_LOG2 consecutive pairs can be summed and then scaled down by an arithmetic right shift. This lowers noise, and one averaged pair is produced per block. A resync input puts the pattern position back at the start, for use when the sampling phase against the IF is known. Because all clocks come from one reference, that phase is fixed.

Top module: `iq_sample_detector`

## Requirements
- R1: While `rst` is high on a clock edge, `out_valid` is low after that edge. After reset the next accepted sample takes pattern position 0 (in-phase), and the block holds no partial sum.
- R2: Accepted samples (`in_valid` high) take positions 0,1,2,3,0,... in turn. Position 0 is +I, 1 is +Q, 2 is -I and 3 is -Q. Samples at positions 2 and 3 are negated before use.
- R3: `out_i` and `out_q` are signed and SAMPLE_W+1 bits wide. Negating the most negative sample, -2^(SAMPLE_W-1), gives +2^(SAMPLE_W-1) and does not wrap.
- R4: A pair is made of the I sample (position 0 or 2) and the next accepted Q sample (position 1 or 3). `out_valid` rises on the clock edge after the edge that accepts the Q sample that completes an output.
- R5: With AVG_LOG2 = L, each output is the sum of 2^L consecutive pairs shifted right arithmetically by L, which rounds toward minus infinity. It appears after the 2^L-th pair. The default is L = 2.
- R6: `resync` high on an edge sets the position back to 0 and clears the partial sum. A sample accepted on that same edge is taken as position 0 (+I).
- R7: Edges where `in_valid` and `resync` are both low leave the position and the partial sum unchanged, and produce no output.
- R8: `out_valid` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| resync | input | 1 | Return the pattern position to 0 and clear the partial sum |
| in_valid | input | 1 | `in_sample` is accepted on this edge |
| in_sample | input | SAMPLE_W | Signed ADC sample |
| out_valid | output | 1 | One-cycle strobe for a new I/Q result |
| out_i | output | SAMPLE_W+1 | Signed in-phase result |
| out_q | output | SAMPLE_W+1 | Signed quadrature result |

## Verification
Resync and sample acceptance can fall on the same edge. The sample on that edge must then become the new +I, whatever position the pattern had reached, and the partial sum must be cleared before it. The bench asserts `resync` both with and without `in_valid`, in the middle of a pair and in the middle of an averaging block. A behavioural model predicts every later output, and the bench compares against it, so a lost or wrongly signed sample shows up in the next averaged I/Q value.

// File: rtl/iqdet_pkg.sv
package iqdet_pkg;

    // Position of a sample within the four-step quarter-cycle pattern
    typedef enum logic [1:0] {
        QP_POS_I = 2'd0,
        QP_POS_Q = 2'd1,
        QP_NEG_I = 2'd2,
        QP_NEG_Q = 2'd3
    } qpos_e;

    // Per-sample control handed from the phase tracker to the datapath
    typedef struct packed {
        logic valid;   // sample accepted this cycle
        logic quad;    // sample is a quadrature sample
        logic negate;  // sample belongs to the inverted half
    } slot_t;

    function automatic qpos_e qpos_next(qpos_e p);
        case (p)
            QP_POS_I: return QP_POS_Q;
            QP_POS_Q: return QP_NEG_I;
            QP_NEG_I: return QP_NEG_Q;
            default:  return QP_POS_I;
        endcase
    endfunction

    function automatic logic qpos_is_quad(qpos_e p);
        return (p == QP_POS_Q) || (p == QP_NEG_Q);
    endfunction

    function automatic logic qpos_is_negated(qpos_e p);
        return (p == QP_NEG_I) || (p == QP_NEG_Q);
    endfunction

endpackage

// File: rtl/iqdet_phase.sv
module iqdet_phase
    import iqdet_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  resync,
    input  logic  in_valid,
    output slot_t slot
);

    qpos_e pos_q;
    qpos_e pos_now;

    // A resync makes the sample on the same edge the in-phase one
    always_comb begin
        pos_now = resync ? QP_POS_I : pos_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= QP_POS_I;
        end else if (in_valid) begin
            pos_q <= qpos_next(pos_now);
        end else if (resync) begin
            pos_q <= QP_POS_I;
        end
    end

    always_comb begin
        slot.valid  = in_valid;
        slot.quad   = qpos_is_quad(pos_now);
        slot.negate = qpos_is_negated(pos_now);
    end

    // R6
    resync_home_chk: assert property (@(posedge clk) disable iff (rst)
        resync && !in_valid |=> pos_q == QP_POS_I);

    // R6
    resync_sample_chk: assert property (@(posedge clk) disable iff (rst)
        resync && in_valid |=> pos_q == QP_POS_Q);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid && !resync |=> $stable(pos_q));

    // R2
    advance_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && !resync |=> pos_q == qpos_next($past(pos_q)));

endmodule

// File: rtl/iqdet_signfix.sv
module iqdet_signfix
    import iqdet_pkg::*;
#(
    parameter int SAMPLE_W = 14
) (
    input  logic                  clk,
    input  logic                  rst,
    input  slot_t                 slot,
    input  logic [SAMPLE_W-1:0]   sample,
    output logic signed [SAMPLE_W:0] corr
);

    localparam int EXT_W = SAMPLE_W + 1;

    logic signed [EXT_W-1:0] ext;

    always_comb begin
        ext  = {sample[SAMPLE_W-1], sample};
        corr = slot.negate ? -ext : ext;
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        slot.valid && slot.negate && (sample != '0)
            |-> corr[SAMPLE_W] != sample[SAMPLE_W-1]);

endmodule

// File: rtl/iqdet_pair.sv
module iqdet_pair
    import iqdet_pkg::*;
#(
    parameter int SAMPLE_W = 14
) (
    input  logic                     clk,
    input  logic                     rst,
    input  slot_t                    slot,
    input  logic signed [SAMPLE_W:0] corr,
    output logic                     pair_valid,
    output logic signed [SAMPLE_W:0] pair_i,
    output logic signed [SAMPLE_W:0] pair_q
);

    logic signed [SAMPLE_W:0] i_hold;
    logic                     have_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            i_hold <= '0;
            have_i <= 1'b0;
        end else if (slot.valid) begin
            if (!slot.quad) begin
                i_hold <= corr;
                have_i <= 1'b1;
            end else begin
                have_i <= 1'b0;
            end
        end
    end

    always_comb begin
        pair_valid = slot.valid && slot.quad;
        pair_i     = i_hold;
        pair_q     = corr;
    end

    // R4
    pair_has_i_chk: assert property (@(posedge clk) disable iff (rst)
        pair_valid |-> have_i);

endmodule

// File: rtl/iqdet_avg.sv
module iqdet_avg #(
    parameter int SAMPLE_W = 14,
    parameter int AVG_LOG2 = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clear,
    input  logic                     pair_valid,
    input  logic signed [SAMPLE_W:0] pair_i,
    input  logic signed [SAMPLE_W:0] pair_q,
    output logic                     out_valid,
    output logic signed [SAMPLE_W:0] out_i,
    output logic signed [SAMPLE_W:0] out_q
);

    localparam int VAL_W = SAMPLE_W + 1;
    localparam int ACC_W = VAL_W + AVG_LOG2;

    generate
        if (AVG_LOG2 == 0) begin : g_direct
            always_ff @(posedge clk) begin
                if (rst) begin
                    out_valid <= 1'b0;
                    out_i     <= '0;
                    out_q     <= '0;
                end else begin
                    out_valid <= pair_valid;
                    if (pair_valid) begin
                        out_i <= pair_i;
                        out_q <= pair_q;
                    end
                end
            end
        end else begin : g_accum
            logic signed [ACC_W-1:0] acc_i, acc_q;
            logic signed [ACC_W-1:0] sum_i, sum_q;
            logic signed [ACC_W-1:0] sh_i, sh_q;
            logic [AVG_LOG2-1:0]     cnt;
            logic                    last;

            always_comb begin
                sum_i = acc_i + {{AVG_LOG2{pair_i[SAMPLE_W]}}, pair_i};
                sum_q = acc_q + {{AVG_LOG2{pair_q[SAMPLE_W]}}, pair_q};
                sh_i  = sum_i >>> AVG_LOG2;
                sh_q  = sum_q >>> AVG_LOG2;
                last  = (cnt == {AVG_LOG2{1'b1}});
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    acc_i     <= '0;
                    acc_q     <= '0;
                    cnt       <= '0;
                    out_valid <= 1'b0;
                    out_i     <= '0;
                    out_q     <= '0;
                end else begin
                    out_valid <= 1'b0;
                    if (clear) begin
                        acc_i <= '0;
                        acc_q <= '0;
                        cnt   <= '0;
                    end else if (pair_valid) begin
                        if (last) begin
                            acc_i     <= '0;
                            acc_q     <= '0;
                            cnt       <= '0;
                            out_valid <= 1'b1;
                            out_i     <= sh_i[VAL_W-1:0];
                            out_q     <= sh_q[VAL_W-1:0];
                        end else begin
                            acc_i <= sum_i;
                            acc_q <= sum_q;
                            cnt   <= cnt + 1'b1;
                        end
                    end
                end
            end

            // R5
            dump_on_last_chk: assert property (@(posedge clk) disable iff (rst)
                out_valid |-> $past(pair_valid) && ($past(cnt) == {AVG_LOG2{1'b1}}));

            // R6
            clear_empty_chk: assert property (@(posedge clk) disable iff (rst)
                clear |=> cnt == '0);
        end
    endgenerate

endmodule

// File: rtl/iq_sample_detector.sv
module iq_sample_detector
    import iqdet_pkg::*;
#(
    parameter int SAMPLE_W = 14,
    parameter int AVG_LOG2 = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                resync,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    output logic                out_valid,
    output logic [SAMPLE_W:0]   out_i,
    output logic [SAMPLE_W:0]   out_q
);

    slot_t                    slot;
    logic signed [SAMPLE_W:0] corr;
    logic                     pair_valid;
    logic signed [SAMPLE_W:0] pair_i, pair_q;
    logic signed [SAMPLE_W:0] avg_i, avg_q;

    iqdet_phase u_phase (
        .clk      (clk),
        .rst      (rst),
        .resync   (resync),
        .in_valid (in_valid),
        .slot     (slot)
    );

    iqdet_signfix #(.SAMPLE_W(SAMPLE_W)) u_signfix (
        .clk    (clk),
        .rst    (rst),
        .slot   (slot),
        .sample (in_sample),
        .corr   (corr)
    );

    iqdet_pair #(.SAMPLE_W(SAMPLE_W)) u_pair (
        .clk        (clk),
        .rst        (rst),
        .slot       (slot),
        .corr       (corr),
        .pair_valid (pair_valid),
        .pair_i     (pair_i),
        .pair_q     (pair_q)
    );

    iqdet_avg #(.SAMPLE_W(SAMPLE_W), .AVG_LOG2(AVG_LOG2)) u_avg (
        .clk        (clk),
        .rst        (rst),
        .clear      (resync),
        .pair_valid (pair_valid),
        .pair_i     (pair_i),
        .pair_q     (pair_q),
        .out_valid  (out_valid),
        .out_i      (avg_i),
        .out_q      (avg_q)
    );

    assign out_i = avg_i;
    assign out_q = avg_q;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> !out_valid);

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R4
    out_after_q_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid) && !$past(resync));

endmodule

// File: tb/sim_iq_sample_detector.sv
module sim_iq_sample_detector;

    localparam int W     = 14;
    localparam int L     = 2;
    localparam int NPAIR = 1 << L;
    localparam int WATCHDOG = 20000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         resync = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_sample = '0;
    logic         out_valid;
    logic [W:0]   out_i, out_q;

    always #10 clk = ~clk;

    iq_sample_detector #(.SAMPLE_W(W), .AVG_LOG2(L)) u0 (
        .clk       (clk),
        .rst       (rst),
        .resync    (resync),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .out_valid (out_valid),
        .out_i     (out_i),
        .out_q     (out_q)
    );

    int    n_checks = 0;
    int    n_errors = 0;
    string tag = "R1";
    bit    done = 1'b0;

    // behavioural reference state
    int ph = 0;
    int ihold = 0;
    int sum_i = 0, sum_q = 0, npairs = 0;
    int exp_v = 0, exp_i = 0, exp_q = 0;
    int prev_v = 0;

    task automatic check(string t, int act, int expv, string what);
        n_checks++;
        if (act != expv) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", t, what, act, expv, $time);
        end
    endtask

    task automatic model(int v, int s, int rs, int r);
        int val;
        exp_v = 0;
        if (r != 0) begin
            ph = 0; ihold = 0; sum_i = 0; sum_q = 0; npairs = 0;
            return;
        end
        if (rs != 0) begin
            ph = 0; sum_i = 0; sum_q = 0; npairs = 0;
        end
        if (v != 0) begin
            val = (ph >= 2) ? -s : s;
            if (ph % 2 == 0) begin
                ihold = val;
            end else begin
                sum_i += ihold;
                sum_q += val;
                npairs++;
                if (npairs == NPAIR) begin
                    exp_v = 1;
                    exp_i = sum_i >>> L;
                    exp_q = sum_q >>> L;
                    sum_i = 0; sum_q = 0; npairs = 0;
                end
            end
            ph = (ph + 1) % 4;
        end
    endtask

    task automatic step(int v, int s, int rs, int r);
        in_valid  = (v != 0);
        in_sample = W'(s);
        resync    = (rs != 0);
        rst       = (r != 0);
        @(posedge clk);
        model(v, s, rs, r);
        @(negedge clk);
        check(tag, int'(out_valid), exp_v, "out_valid");
        if (exp_v != 0) begin
            check(tag, int'($signed(out_i)), exp_i, "out_i");
            check(tag, int'($signed(out_q)), exp_q, "out_q");
        end
        // R8: no back-to-back strobes
        check("R8", (prev_v != 0 && out_valid) ? 1 : 0, 0, "consecutive out_valid");
        prev_v = int'(out_valid);
    endtask

    function automatic int rnd_sample();
        return int'($urandom_range(0, (1 << W) - 1)) - (1 << (W - 1));
    endfunction

    initial begin
        int a, b;
        @(negedge clk);
        // R1: reset state
        tag = "R1";
        for (int k = 0; k < 3; k++) step(0, 0, 0, 1);
        step(0, 0, 0, 0);

        // R2: ideal quarter-cycle pattern +a,+b,-a,-b gives (a,b)
        tag = "R2";
        a = 1234; b = -567;
        for (int k = 0; k < 8; k++) begin
            step(1, a, 0, 0); step(1, b, 0, 0);
            step(1, -a, 0, 0); step(1, -b, 0, 0);
        end

        // R3: extreme codes, including the most negative one in every slot
        tag = "R3";
        for (int k = 0; k < 16; k++) step(1, -(1 << (W - 1)), 0, 0);
        for (int k = 0; k < 16; k++) step(1, (k % 2) ? ((1 << (W - 1)) - 1) : -(1 << (W - 1)), 0, 0);

        // R4: pairs spread out by idle cycles
        tag = "R4";
        for (int k = 0; k < 32; k++) begin
            step(1, rnd_sample(), 0, 0);
            for (int g = 0; g < (k % 3); g++) step(0, rnd_sample(), 0, 0);
        end

        // R5: random samples, continuous, checking floor division of sums
        tag = "R5";
        for (int k = 0; k < 96; k++) step(1, rnd_sample(), 0, 0);

        // R6: resync with and without a sample, mid-pair and mid-block
        tag = "R6";
        step(1, 100, 0, 0);
        step(0, 0, 1, 0);
        for (int k = 0; k < 8; k++) step(1, 300 + k, 0, 0);
        step(1, 777, 0, 0);
        step(1, -400, 1, 0);
        for (int k = 0; k < 9; k++) step(1, rnd_sample(), 0, 0);
        step(1, 55, 1, 0);
        for (int k = 0; k < 24; k++) step(1, rnd_sample(), (k == 13) ? 1 : 0, 0);

        // R7: idle cycles with changing sample data
        tag = "R7";
        step(1, 10, 0, 0);
        for (int k = 0; k < 10; k++) step(0, rnd_sample(), 0, 0);
        for (int k = 0; k < 15; k++) begin
            step(1, rnd_sample(), 0, 0);
            step(0, rnd_sample(), 0, 0);
        end

        // R1: reset in mid-block discards partial state
        tag = "R1";
        step(1, 900, 0, 0);
        step(0, 0, 0, 1);
        for (int k = 0; k < 8; k++) step(1, -50 * k, 0, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule